// File: doc/BRIEF.md
# Byte/Word FIFO Access Port

This block sits between a 32-bit register bus and a serial engine. It holds a transmit FIFO and a receive FIFO, both one byte wide. Software fills the transmit FIFO and drains the receive FIFO through data registers. Each access moves either a single byte or four packed bytes. A word-mode bit in the control register chooses the four-byte behaviour. The engine takes transmit bytes one at a time from a peek/pop port and delivers receive bytes one at a time into a push port.

A status register reports FIFO occupancy and the engine's ready state. It also mirrors the word-mode bit and holds two sticky done flags, one for transmit and one for receive. The empty and full thresholds in status follow the current access width. With word mode set, "empty" means fewer than four bytes to read, and "full" means fewer than four free slots to write. An interrupt-enable mask lets selected status bits drive a single interrupt output. The control and frame registers are plain storage whose contents are driven out to the engine.

Top module: `fifo_access_port`

## Requirements
- R1: After reset, the status register reads 0x98 when the engine's ready input is high: TX available (bit 3), RX FIFO empty (bit 4) and ready (bit 7) are set, all other bits are clear. The interrupt-enable register reads 0, `irq` is low and `tx_empty` is high.
- R2: A write to the byte TX register (offset 0x44) pushes only `bus_wdata[7:0]`. Successive writes reach the engine in write order on `tx_byte`.
- R3: With word mode set (control bit 4), a write to the word TX register (offset 0x4C) pushes four bytes. The engine receives bits 7:0 first, then 15:8, 23:16 and 31:24. The byte TX register also works in word mode.
- R4: A read of the byte RX register (offset 0x40) pops one byte and returns it in bits 7:0, with bits 31:8 zero. Read data appears on `bus_rdata` one clock after the read strobe.
- R5: With word mode set, a read of the word RX register (offset 0x48) pops four bytes and returns them little-endian. The oldest byte is in bits 7:0.
- R6: Status (offset 0x10) has the following layout:
  - bit 0: TX done
  - bit 1: RX done
  - bit 2: RX available, the inverse of bit 4
  - bit 3: TX available, the inverse of bit 5
  - bit 4: RX FIFO empty
  - bit 5: TX FIFO full
  - bit 7: `eng_ready`
  - bit 8: the word-mode bit
  - bit 6 and bits 31:9: zero
- R7: In byte mode, RX empty means 0 bytes held and TX full means no free slot. In word mode, RX empty means fewer than 4 bytes held and TX full means fewer than 4 free slots.
- R8: A pop from the bus that finds too few bytes returns 0 and leaves the FIFO unchanged. A push that finds too little room is dropped whole. This holds for both the bus side and the engine side; `rx_full` is high when the RX FIFO holds DEPTH bytes.
- R9: With word mode clear, a write to the word TX register pushes nothing. A read of the word RX register returns 0 and pops nothing.
- R10: The interrupt-enable register (offset 0x0C) keeps bits 5:0 and reads other bits as zero. `irq` is the OR of status bits 5:0 ANDed with those enables.
- R11: A pulse on `eng_tx_done` or `eng_rx_done` sets status bit 0 or bit 1. That bit stays set until a status write with a 1 in the same bit position; set wins over clear in the same cycle.
- R12: Control (0x00), frames (0x04) and upper frames (0x50) are 32-bit read/write registers, reset to 0, driven on `ctrl_q`, `frames_q` and `frames_hi_q`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one clock after `bus_rd` |
| irq | output | 1 | Masked OR of status bits 5:0 |
| ctrl_q | output | 32 | Control register contents |
| frames_q | output | 32 | Frames register contents |
| frames_hi_q | output | 32 | Upper frames register contents |
| tx_pop | input | 1 | Engine takes the head of the TX FIFO |
| tx_byte | output | 8 | Head byte of the TX FIFO |
| tx_empty | output | 1 | TX FIFO holds no byte |
| rx_push | input | 1 | Engine writes `rx_byte` into the RX FIFO |
| rx_byte | input | 8 | Received byte from the engine |
| rx_full | output | 1 | RX FIFO holds DEPTH bytes |
| eng_tx_done | input | 1 | Pulse: engine finished transmitting |
| eng_rx_done | input | 1 | Pulse: engine finished receiving |
| eng_ready | input | 1 | Engine idle and ready for a new sequence |

## Verification
The bench builds the block with DEPTH = 8 and the default 8-bit address. With eight slots, the TX FIFO can be filled to the brim with a handful of byte writes. It can then be drained to exactly five bytes, a level that reads as not full in byte mode but full in word mode. The RX FIFO can likewise be overfilled with a single extra engine push. These small numbers put every threshold change of R7 and every dropped access of R8 within a few dozen bus cycles. Pointer wrap-around is also exercised, once the FIFOs have been filled and drained several times.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;

  localparam logic [7:0] OFS_CTRL     = 8'h00;
  localparam logic [7:0] OFS_FRAMES   = 8'h04;
  localparam logic [7:0] OFS_IEN      = 8'h0C;
  localparam logic [7:0] OFS_STATUS   = 8'h10;
  localparam logic [7:0] OFS_RX_BYTE  = 8'h40;
  localparam logic [7:0] OFS_TX_BYTE  = 8'h44;
  localparam logic [7:0] OFS_RX_WORD  = 8'h48;
  localparam logic [7:0] OFS_TX_WORD  = 8'h4C;
  localparam logic [7:0] OFS_FRAMES_H = 8'h50;

  localparam int unsigned CTRL_WORD_BIT = 4;
  localparam int unsigned LANES         = 4;
  localparam int unsigned IEN_W         = 6;

  // Bytes needed for one bus access in the current width.
  function automatic int unsigned access_bytes(input logic word);
    return word ? LANES : 1;
  endfunction

  // Not enough bytes held to satisfy one bus read.
  function automatic logic drain_short(input int unsigned lvl, input logic word);
    return lvl < access_bytes(word);
  endfunction

  // Not enough free slots to accept one bus write.
  function automatic logic room_short(input int unsigned lvl, input int unsigned depth,
                                      input logic word);
    return (depth - lvl) < access_bytes(word);
  endfunction

endpackage

// File: rtl/bytelane_fifo.sv
module bytelane_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PUSHL = 4,
  parameter int unsigned POPL  = 1,
  localparam int unsigned PW  = $clog2(DEPTH),
  localparam int unsigned LW  = PW + 1,
  localparam int unsigned PNW = $clog2(PUSHL + 1),
  localparam int unsigned QNW = $clog2(POPL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PNW-1:0]       push_n,
  input  logic [PUSHL*8-1:0]   push_data,
  input  logic [QNW-1:0]       pop_n,
  output logic [POPL*8-1:0]    peek_data,
  output logic                 pop_ok,
  output logic [LW-1:0]        level
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [LW-1:0] free_slots;
  logic          push_ok;
  logic [LW-1:0] add_n, sub_n;

  assign free_slots = LW'(DEPTH) - level;
  assign push_ok    = (push_n != '0) && (free_slots >= LW'(push_n));
  assign pop_ok     = (pop_n != '0) && (level >= LW'(pop_n));
  assign add_n      = push_ok ? LW'(push_n) : '0;
  assign sub_n      = pop_ok  ? LW'(pop_n)  : '0;

  always_ff @(posedge clk) begin
    if (push_ok) begin
      for (int unsigned l = 0; l < PUSHL; l++) begin
        if (PNW'(l) < push_n) mem[wptr + PW'(l)] <= push_data[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= wptr + PW'(push_n);
      if (pop_ok)  rptr <= rptr + PW'(pop_n);
      level <= level + add_n - sub_n;
    end
  end

  for (genvar g = 0; g < POPL; g++) begin : g_peek
    assign peek_data[g*8 +: 8] = mem[rptr + PW'(g)];
  end

endmodule

// File: rtl/port_status.sv
module port_status
  import fifo_port_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    tx_level,
  input  logic [LW-1:0]    rx_level,
  input  logic             word_mode,
  input  logic             eng_ready,
  input  logic             set_tx_done,
  input  logic             set_rx_done,
  input  logic [1:0]       clr_done,
  input  logic [IEN_W-1:0] ien,
  output logic [31:0]      status_word,
  output logic             irq,
  output logic             tx_done_q,
  output logic             rx_done_q
);

  logic rx_short, tx_short;

  assign rx_short = drain_short(32'(rx_level), word_mode);
  assign tx_short = room_short(32'(tx_level), DEPTH, word_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
    end else begin
      tx_done_q <= set_tx_done | (tx_done_q & ~clr_done[0]);
      rx_done_q <= set_rx_done | (rx_done_q & ~clr_done[1]);
    end
  end

  assign status_word = {23'd0, word_mode, eng_ready, 1'b0, tx_short, rx_short,
                        ~tx_short, ~rx_short, rx_done_q, tx_done_q};
  assign irq = |(status_word[IEN_W-1:0] & ien);

endmodule

// File: rtl/fifo_access_port.sv
module fifo_access_port
  import fifo_port_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic [31:0]   ctrl_q,
  output logic [31:0]   frames_q,
  output logic [31:0]   frames_hi_q,
  input  logic          tx_pop,
  output logic [7:0]    tx_byte,
  output logic          tx_empty,
  input  logic          rx_push,
  input  logic [7:0]    rx_byte,
  output logic          rx_full,
  input  logic          eng_tx_done,
  input  logic          eng_rx_done,
  input  logic          eng_ready
);

  logic [IEN_W-1:0] ien_q;
  logic [31:0]      status_word;
  logic             tx_done_q, rx_done_q;
  logic             word_mode;

  // Decoded bus events, named for the checker.
  logic wr_ctrl, wr_frames, wr_frames_h, wr_ien, wr_status, wr_tx_byte, wr_tx_word;
  logic rd_rx_byte, rd_rx_word;
  logic tx_done_clr, rx_pop4_evt;

  assign word_mode   = ctrl_q[CTRL_WORD_BIT];
  assign wr_ctrl     = bus_wr && (bus_addr == AW'(OFS_CTRL));
  assign wr_frames   = bus_wr && (bus_addr == AW'(OFS_FRAMES));
  assign wr_frames_h = bus_wr && (bus_addr == AW'(OFS_FRAMES_H));
  assign wr_ien      = bus_wr && (bus_addr == AW'(OFS_IEN));
  assign wr_status   = bus_wr && (bus_addr == AW'(OFS_STATUS));
  assign wr_tx_byte  = bus_wr && (bus_addr == AW'(OFS_TX_BYTE));
  assign wr_tx_word  = bus_wr && (bus_addr == AW'(OFS_TX_WORD)) && word_mode;
  assign rd_rx_byte  = bus_rd && (bus_addr == AW'(OFS_RX_BYTE));
  assign rd_rx_word  = bus_rd && (bus_addr == AW'(OFS_RX_WORD)) && word_mode;
  assign tx_done_clr = wr_status && bus_wdata[0];

  // Transmit FIFO: bus pushes 1 or 4 bytes, engine pops 1.
  logic [2:0]    tx_push_n;
  logic [31:0]   tx_push_data;
  logic [LW-1:0] tx_level;
  logic          tx_pop_ok;

  assign tx_push_n    = wr_tx_byte ? 3'd1 : (wr_tx_word ? 3'd4 : 3'd0);
  assign tx_push_data = wr_tx_byte ? {24'd0, bus_wdata[7:0]} : bus_wdata;

  bytelane_fifo #(.DEPTH(DEPTH), .PUSHL(LANES), .POPL(1)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (tx_push_n),
    .push_data (tx_push_data),
    .pop_n     (tx_pop),
    .peek_data (tx_byte),
    .pop_ok    (tx_pop_ok),
    .level     (tx_level)
  );

  // Receive FIFO: engine pushes 1, bus pops 1 or 4 bytes.
  logic [2:0]    rx_pop_n;
  logic [31:0]   rx_peek;
  logic [LW-1:0] rx_level;
  logic          rx_pop_ok;

  assign rx_pop_n    = rd_rx_byte ? 3'd1 : (rd_rx_word ? 3'd4 : 3'd0);
  assign rx_pop4_evt = rx_pop_ok && (rx_pop_n == 3'd4);

  bytelane_fifo #(.DEPTH(DEPTH), .PUSHL(1), .POPL(LANES)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (rx_push),
    .push_data (rx_byte),
    .pop_n     (rx_pop_n),
    .peek_data (rx_peek),
    .pop_ok    (rx_pop_ok),
    .level     (rx_level)
  );

  assign tx_empty = (tx_level == '0);
  assign rx_full  = (rx_level == LW'(DEPTH));

  port_status #(.DEPTH(DEPTH)) u_sts (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_level    (tx_level),
    .rx_level    (rx_level),
    .word_mode   (word_mode),
    .eng_ready   (eng_ready),
    .set_tx_done (eng_tx_done),
    .set_rx_done (eng_rx_done),
    .clr_done    (wr_status ? bus_wdata[1:0] : 2'b00),
    .ien         (ien_q),
    .status_word (status_word),
    .irq         (irq),
    .tx_done_q   (tx_done_q),
    .rx_done_q   (rx_done_q)
  );

  // Configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      frames_q    <= '0;
      frames_hi_q <= '0;
      ien_q       <= '0;
    end else begin
      if (wr_ctrl)     ctrl_q      <= bus_wdata;
      if (wr_frames)   frames_q    <= bus_wdata;
      if (wr_frames_h) frames_hi_q <= bus_wdata;
      if (wr_ien)      ien_q       <= bus_wdata[IEN_W-1:0];
    end
  end

  // Read mux, registered.
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFS_CTRL))     rd_mux = ctrl_q;
    if (bus_addr == AW'(OFS_FRAMES))   rd_mux = frames_q;
    if (bus_addr == AW'(OFS_FRAMES_H)) rd_mux = frames_hi_q;
    if (bus_addr == AW'(OFS_IEN))      rd_mux = {{(32-IEN_W){1'b0}}, ien_q};
    if (bus_addr == AW'(OFS_STATUS))   rd_mux = status_word;
    if (rd_rx_byte && rx_pop_ok)       rd_mux = {24'd0, rx_peek[7:0]};
    if (rd_rx_word && rx_pop_ok)       rd_mux = rx_peek;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/fifo_access_port_chk.sv
module fifo_access_port_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_pop,
  input logic          tx_pop_ok,
  input logic          rx_push,
  input logic          rx_pop4_evt,
  input logic [5:0]    ien_q,
  input logic          irq,
  input logic          tx_done_q,
  input logic          tx_done_clr
);

  AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH)); // R8
  AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH)); // R8
  AST_TX_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_level == '0) |-> !tx_pop_ok); // R8
  AST_RX_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0 && !rx_push) |=> rx_level == '0); // R8
  AST_WORD_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop4_evt && !rx_push) |=> rx_level == $past(rx_level) - LW'(4)); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_q && !tx_done_clr) |=> tx_done_q); // R11

endmodule

bind fifo_access_port fifo_access_port_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_level    (tx_level),
  .rx_level    (rx_level),
  .tx_pop      (tx_pop),
  .tx_pop_ok   (tx_pop_ok),
  .rx_push     (rx_push),
  .rx_pop4_evt (rx_pop4_evt),
  .ien_q       (ien_q),
  .irq         (irq),
  .tx_done_q   (tx_done_q),
  .tx_done_clr (tx_done_clr)
);

// File: tb/sim_fifo_access_port.sv
module sim_fifo_access_port;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [31:0] ctrl_q, frames_q, frames_hi_q;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_empty;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_full;
  logic        eng_tx_done = 1'b0, eng_rx_done = 1'b0, eng_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fifo_access_port #(.AW(8), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_status(int txl, int rxl, bit word, bit txd,
                                               bit rxd, bit rdy);
    int need = word ? 4 : 1;
    bit rx_e = rxl < need;
    bit tx_f = (DEPTH - txl) < need;
    return {23'd0, word, rdy, 1'b0, tx_f, rx_e, !tx_f, !rx_e, rxd, txd};
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic eng_push(logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic eng_take(string req, logic [7:0] exp);
    @(negedge clk);
    chk(req, {31'd0, tx_empty}, 32'd0);
    chk(req, {24'd0, tx_byte}, {24'd0, exp});
    tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(8'h10, d); chk("R1 status", d, 32'h98);
    chk("R1 status model", d, model_status(0, 0, 0, 0, 0, 1));
    bus_read(8'h0C, d); chk("R1 ien", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 tx_empty", {31'd0, tx_empty}, 1);
  endtask

  task automatic t_config();
    logic [31:0] d;
    bus_write(8'h00, 32'h0F0F0F00);
    bus_write(8'h04, 32'hCAFEF00D);
    bus_write(8'h50, 32'h00000003);
    bus_read(8'h00, d); chk("R12 ctrl rd", d, 32'h0F0F0F00);
    bus_read(8'h04, d); chk("R12 frames rd", d, 32'hCAFEF00D);
    bus_read(8'h50, d); chk("R12 frames_hi rd", d, 32'h3);
    bus_read(8'h20, d); chk("R12 unmapped", d, 0);
    chk("R12 ctrl_q", ctrl_q, 32'h0F0F0F00);
    chk("R12 frames_q", frames_q, 32'hCAFEF00D);
    chk("R12 frames_hi_q", frames_hi_q, 32'h3);
    bus_write(8'h00, 32'h0);
  endtask

  task automatic t_byte_tx();
    logic [31:0] d;
    bus_write(8'h44, 32'hAABBCC11);
    bus_write(8'h44, 32'h77665522);
    bus_read(8'h10, d); chk("R2 status lvl2", d, model_status(2, 0, 0, 0, 0, 1));
    eng_take("R2 first", 8'h11);
    eng_take("R2 second", 8'h22);
    chk("R2 drained", {31'd0, tx_empty}, 1);
  endtask

  task automatic t_word_tx();
    logic [31:0] d;
    bus_write(8'h00, 32'h10);
    bus_read(8'h10, d); chk("R6 word mirror", d, model_status(0, 0, 1, 0, 0, 1));
    bus_write(8'h4C, 32'h44332211);
    bus_write(8'h44, 32'hFFFFFF99);
    eng_take("R3 b0", 8'h11);
    eng_take("R3 b1", 8'h22);
    eng_take("R3 b2", 8'h33);
    eng_take("R3 b3", 8'h44);
    eng_take("R3 byte in word mode", 8'h99);
    chk("R3 drained", {31'd0, tx_empty}, 1);
    bus_write(8'h00, 32'h0);
  endtask

  task automatic t_byte_rx();
    logic [31:0] d;
    eng_push(8'h5A);
    eng_push(8'hA5);
    bus_read(8'h40, d); chk("R4 first", d, 32'h5A);
    bus_read(8'h40, d); chk("R4 second", d, 32'hA5);
    bus_read(8'h40, d); chk("R8 pop empty", d, 0);
    bus_read(8'h10, d); chk("R4 status empty", d, model_status(0, 0, 0, 0, 0, 1));
  endtask

  task automatic t_word_rx();
    logic [31:0] d;
    bus_write(8'h00, 32'h10);
    for (int i = 1; i <= 8; i++) eng_push(8'(i));
    chk("R8 rx_full", {31'd0, rx_full}, 1);
    eng_push(8'hEE);
    bus_read(8'h48, d); chk("R5 word0", d, 32'h04030201);
    bus_read(8'h48, d); chk("R5 word1", d, 32'h08070605);
    eng_push(8'hA1); eng_push(8'hA2); eng_push(8'hA3);
    bus_read(8'h10, d); chk("R7 rx short word", d, model_status(0, 3, 1, 0, 0, 1));
    bus_read(8'h48, d); chk("R8 word pop short", d, 0);
    bus_write(8'h00, 32'h0);
    bus_read(8'h10, d); chk("R7 rx byte mode", d, model_status(0, 3, 0, 0, 0, 1));
    bus_read(8'h40, d); chk("R8 kept A1", d, 32'hA1);
    bus_read(8'h40, d); chk("R8 kept A2", d, 32'hA2);
    bus_read(8'h40, d); chk("R8 kept A3", d, 32'hA3);
  endtask

  task automatic t_tx_full();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) bus_write(8'h44, 32'(8'h10 + i));
    bus_read(8'h10, d); chk("R7 tx full byte", d, model_status(8, 0, 0, 0, 0, 1));
    bus_write(8'h44, 32'h18);
    eng_take("R8 order 10", 8'h10);
    eng_take("R8 order 11", 8'h11);
    eng_take("R8 order 12", 8'h12);
    bus_write(8'h00, 32'h10);
    bus_read(8'h10, d); chk("R7 tx full word", d, model_status(5, 0, 1, 0, 0, 1));
    bus_write(8'h4C, 32'hDDCCBBAA);
    bus_write(8'h00, 32'h0);
    bus_read(8'h10, d); chk("R7 tx room byte", d, model_status(5, 0, 0, 0, 0, 1));
    for (int i = 3; i < 8; i++) eng_take("R8 tail", 8'(8'h10 + i));
    chk("R8 drops left nothing", {31'd0, tx_empty}, 1);
  endtask

  task automatic t_word_ignored();
    logic [31:0] d;
    bus_write(8'h4C, 32'h12345678);
    @(negedge clk);
    chk("R9 word tx ignored", {31'd0, tx_empty}, 1);
    eng_push(8'h3C);
    bus_read(8'h48, d); chk("R9 word rx ignored", d, 0);
    bus_read(8'h40, d); chk("R9 byte kept", d, 32'h3C);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(8'h0C, 32'hFFFFFFFF);
    bus_read(8'h0C, d); chk("R10 ien width", d, 32'h3F);
    chk("R10 irq all", {31'd0, irq}, 1);
    bus_write(8'h0C, 32'h20);
    chk("R10 irq tx full masked", {31'd0, irq}, 0);
    bus_write(8'h0C, 32'h08);
    chk("R10 irq tx avail", {31'd0, irq}, 1);
    bus_write(8'h0C, 32'h0);
    chk("R10 irq off", {31'd0, irq}, 0);
  endtask

  task automatic t_done();
    logic [31:0] d;
    @(negedge clk); eng_tx_done = 1'b1;
    @(negedge clk); eng_tx_done = 1'b0;
    bus_read(8'h10, d); chk("R11 tx done set", d, model_status(0, 0, 0, 1, 0, 1));
    repeat (5) @(negedge clk);
    bus_read(8'h10, d); chk("R11 tx done sticky", d, model_status(0, 0, 0, 1, 0, 1));
    bus_write(8'h10, 32'h2);
    bus_read(8'h10, d); chk("R11 other bit kept", d, model_status(0, 0, 0, 1, 0, 1));
    @(negedge clk); eng_rx_done = 1'b1;
    @(negedge clk); eng_rx_done = 1'b0;
    bus_write(8'h10, 32'h1);
    bus_read(8'h10, d); chk("R11 tx cleared", d, model_status(0, 0, 0, 0, 1, 1));
    bus_write(8'h10, 32'h3);
    bus_read(8'h10, d); chk("R11 both cleared", d, model_status(0, 0, 0, 0, 0, 1));
    eng_ready = 1'b0;
    bus_read(8'h10, d); chk("R6 ready low", d, model_status(0, 0, 0, 0, 0, 0));
    eng_ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_byte_tx();
    t_word_tx();
    t_byte_rx();
    t_word_rx();
    t_tx_full();
    t_word_ignored();
    t_irq();
    t_done();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

endmodule